// File: doc/BRIEF.md
# Receive AIS Pattern Detector

This block sits on the receive side of a line termination and watches the incoming serial bit stream for an alarm indication signal. It looks for two patterns. The first is an unframed all-ones signal, judged over fixed windows of counted bits. The second is the framed DS3 form, whose payload alternates 1,0,1,0 and starts again at 1 after every overhead bit. Bits arrive one per accepted beat on a valid/ready stream. The block always accepts: `in_ready` is held high, so a source never sees back-pressure, and a bit is taken on every clock edge where `in_valid` is high.

Which patterns can be reported depends on the line mode. Unframed all-ones is reported in every mode. Framed DS3 AIS is reported only in DS3 mode. Overhead positions are left out of both judgements. Two overhead markers arrive with the data: one from the receive framer and one from the transmit framer. The diagnostic loopback status selects which marker is used, because under that loopback the received stream carries the transmit framer's overhead layout. M-frame boundaries come from an external frame-start strobe.

Top module: `rx_ais_detector`

## Requirements
- R1: While reset is held and on the first cycle after it, `allones_det` and `framed_ais_det` are low.
- R2: After every WIN_BITS counted bits, `allones_det` is updated: it is set if that window held at most ZERO_LIMIT zeros and cleared otherwise. It changes on the clock edge that accepts the last bit of the window and holds its value between windows.
- R3: A window holding exactly ZERO_LIMIT zeros sets `allones_det`. A window holding ZERO_LIMIT+1 zeros clears it.
- R4: With `dlb_active` low, an accepted bit whose `rx_oh_mark` is high is not counted by either detector, and `tx_oh_mark` has no effect.
- R5: With `dlb_active` high, an accepted bit whose `tx_oh_mark` is high is not counted by either detector, and `rx_oh_mark` has no effect.
- R6: In DS3 mode (`mode`=2'b00), payload bits are compared against a reference that is 1 on the first payload bit after an overhead bit or after a frame start, and then alternates. On each accepted bit with `in_frame_start` high, `framed_ais_det` is set if the previous M-frame held at most ZERO_LIMIT mismatching payload bits and cleared otherwise. The first frame start after reset or after a mode change only opens a frame and leaves the flag low.
- R7: In E3 mode (2'b01) and clear-channel mode (2'b10, with 2'b11 treated the same), `framed_ais_det` stays low. Unframed all-ones detection works in all modes.
- R8: When `mode` differs from its value in the previous cycle, the bit offered in that cycle is discarded, both window counts restart, the frame is disarmed, and both flags are cleared on that edge.
- R9: `in_ready` is always high. A cycle with `in_valid` low has no effect on any count or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Received bit valid |
| in_ready | output | 1 | Always high; the block never stalls |
| in_bit | input | 1 | Received bit |
| in_frame_start | input | 1 | Marks the accepted bit as the first bit of an M-frame |
| mode | input | 2 | Line mode: 00 DS3, 01 E3, 10/11 clear-channel |
| rx_oh_mark | input | 1 | Receive framer marks this bit as overhead |
| tx_oh_mark | input | 1 | Transmit framer marks this bit as overhead |
| dlb_active | input | 1 | Diagnostic loopback active; selects the overhead marker |
| allones_det | output | 1 | Unframed all-ones detected |
| framed_ais_det | output | 1 | Framed DS3 AIS detected |

## Verification
The bench builds the block with WIN_BITS=32 and ZERO_LIMIT=3. A whole window therefore passes in a few dozen bits, so the limit boundary can be reached from both sides, along with realignment of a window after a mode change. The M-frame length is set only by the bench's frame-start strobe. The bench uses 36-bit frames made of four blocks, each one overhead bit followed by eight payload bits. With these frames the mismatch limit, the phase restart after every overhead bit, and the arming on the first frame start are all exercised over a handful of frames.

// File: rtl/rx_ais_pkg.sv
package rx_ais_pkg;
  typedef enum logic [1:0] {
    LM_DS3   = 2'b00,
    LM_E3    = 2'b01,
    LM_CLEAR = 2'b10,
    LM_RSVD  = 2'b11
  } line_mode_e;

  function automatic logic is_ds3(input line_mode_e m);
    return m == LM_DS3;
  endfunction
endpackage

// File: rtl/rx_ais_bit_qualify.sv
module rx_ais_bit_qualify
  import rx_ais_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       in_frame_start,
  input  logic       rx_oh_mark,
  input  logic       tx_oh_mark,
  input  logic       dlb_active,
  input  line_mode_e mode,
  output logic       restart,
  output logic       take_oh,
  output logic       take_data,
  output logic       take_fs,
  output logic       ds3_mode
);
  line_mode_e mode_q;
  logic       oh_sel;
  logic       take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= LM_DS3;
    else        mode_q <= mode;
  end

  // Under diagnostic loopback the stream carries the transmit overhead layout
  assign oh_sel    = dlb_active ? tx_oh_mark : rx_oh_mark;
  assign restart   = (mode != mode_q);
  assign take      = in_valid && !restart;
  assign take_oh   = take && oh_sel;
  assign take_data = take && !oh_sel;
  assign take_fs   = take && in_frame_start;
  assign ds3_mode  = is_ds3(mode);
endmodule

// File: rtl/rx_ais_ones_window.sv
module rx_ais_ones_window #(
  parameter int WIN_BITS   = 4096,
  parameter int ZERO_LIMIT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic take_data,
  input  logic bit_in,
  output logic detected
);
  localparam int CW = (WIN_BITS > 2) ? $clog2(WIN_BITS) : 1;
  localparam int ZW = $clog2(ZERO_LIMIT + 2);
  localparam logic [CW-1:0] LAST_IDX = CW'(WIN_BITS - 1);
  localparam logic [ZW:0]   SAT      = (ZW+1)'(ZERO_LIMIT + 1);
  localparam logic [ZW:0]   LIM      = (ZW+1)'(ZERO_LIMIT);

  logic [CW-1:0] cnt;
  logic [ZW-1:0] zeros;
  logic [ZW:0]   zsum;
  logic [ZW-1:0] zeros_nx;
  logic          last;

  assign zsum     = {1'b0, zeros} + {{ZW{1'b0}}, ~bit_in};
  assign zeros_nx = (zsum > SAT) ? SAT[ZW-1:0] : zsum[ZW-1:0];
  assign last     = (cnt == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      zeros    <= '0;
      detected <= 1'b0;
    end else if (restart) begin
      cnt      <= '0;
      zeros    <= '0;
      detected <= 1'b0;
    end else if (take_data) begin
      if (last) begin
        cnt      <= '0;
        zeros    <= '0;
        detected <= (zsum <= LIM);
      end else begin
        cnt   <= cnt + 1'b1;
        zeros <= zeros_nx;
      end
    end
  end
endmodule

// File: rtl/rx_ais_framed_check.sv
module rx_ais_framed_check #(
  parameter int ERR_LIMIT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic ds3_mode,
  input  logic take_oh,
  input  logic take_data,
  input  logic take_fs,
  input  logic bit_in,
  output logic detected
);
  localparam int EW = $clog2(ERR_LIMIT + 2);
  localparam logic [EW:0] SAT = (EW+1)'(ERR_LIMIT + 1);
  localparam logic [EW:0] LIM = (EW+1)'(ERR_LIMIT);

  logic          ref_bit;
  logic          armed;
  logic [EW-1:0] errs;
  logic          ref_now;
  logic          miss;
  logic [EW-1:0] errs_base;
  logic [EW:0]   esum;
  logic [EW-1:0] errs_nx;
  logic          ref_nx;

  // A frame start restarts the reference phase like an overhead bit does
  assign ref_now   = take_fs ? 1'b1 : ref_bit;
  assign miss      = take_data && (bit_in != ref_now);
  assign errs_base = take_fs ? '0 : errs;
  assign esum      = {1'b0, errs_base} + {{EW{1'b0}}, miss};

  always_comb begin
    errs_nx = (esum > SAT) ? SAT[EW-1:0] : esum[EW-1:0];
    ref_nx  = ref_bit;
    if (take_oh)        ref_nx = 1'b1;
    else if (take_data) ref_nx = ~ref_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_bit  <= 1'b1;
      armed    <= 1'b0;
      errs     <= '0;
      detected <= 1'b0;
    end else if (restart || !ds3_mode) begin
      ref_bit  <= 1'b1;
      armed    <= 1'b0;
      errs     <= '0;
      detected <= 1'b0;
    end else begin
      if (take_fs) begin
        armed <= 1'b1;
        if (armed) detected <= ({1'b0, errs} <= LIM);
      end
      errs    <= errs_nx;
      ref_bit <= ref_nx;
    end
  end
endmodule

// File: rtl/rx_ais_detector.sv
module rx_ais_detector #(
  parameter int WIN_BITS   = 4096,
  parameter int ZERO_LIMIT = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic       in_bit,
  input  logic       in_frame_start,
  input  logic [1:0] mode,
  input  logic       rx_oh_mark,
  input  logic       tx_oh_mark,
  input  logic       dlb_active,
  output logic       allones_det,
  output logic       framed_ais_det
);
  import rx_ais_pkg::*;

  line_mode_e mode_e;
  logic restart, take_oh, take_data, take_fs, ds3_mode;

  assign mode_e   = line_mode_e'(mode);
  assign in_ready = 1'b1;

  rx_ais_bit_qualify u_qual (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_frame_start(in_frame_start),
    .rx_oh_mark    (rx_oh_mark),
    .tx_oh_mark    (tx_oh_mark),
    .dlb_active    (dlb_active),
    .mode          (mode_e),
    .restart       (restart),
    .take_oh       (take_oh),
    .take_data     (take_data),
    .take_fs       (take_fs),
    .ds3_mode      (ds3_mode)
  );

  rx_ais_ones_window #(
    .WIN_BITS  (WIN_BITS),
    .ZERO_LIMIT(ZERO_LIMIT)
  ) u_ones (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart),
    .take_data(take_data),
    .bit_in   (in_bit),
    .detected (allones_det)
  );

  rx_ais_framed_check #(
    .ERR_LIMIT(ZERO_LIMIT)
  ) u_framed (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart),
    .ds3_mode (ds3_mode),
    .take_oh  (take_oh),
    .take_data(take_data),
    .take_fs  (take_fs),
    .bit_in   (in_bit),
    .detected (framed_ais_det)
  );
endmodule

// File: rtl/rx_ais_detector_chk.sv
module rx_ais_detector_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [1:0] mode,
  input logic       allones_det,
  input logic       framed_ais_det
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!allones_det && !framed_ais_det));

  // R9
  ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && $stable(mode)) |=> ($stable(allones_det) && $stable(framed_ais_det)));

  // R7
  framed_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b00 && $stable(mode)) |-> !framed_ais_det);

  // R8
  mode_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != $past(mode)) |=> (!allones_det && !framed_ais_det));
endmodule

bind rx_ais_detector rx_ais_detector_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .mode          (mode),
  .allones_det   (allones_det),
  .framed_ais_det(framed_ais_det)
);

// File: tb/rx_ais_detector_tb.sv
module rx_ais_detector_tb;
  localparam int WIN   = 32;
  localparam int LIMIT = 3;
  localparam int BLKS  = 4;
  localparam int PAY   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_bit = 1'b0, in_frame_start = 1'b0;
  logic [1:0] mode = 2'b00;
  logic rx_oh_mark = 1'b0, tx_oh_mark = 1'b0, dlb_active = 1'b0;
  logic in_ready, allones_det, framed_ais_det;

  int n_cmp = 0;
  int n_bad = 0;

  typedef struct {
    logic  chk_a;
    logic  exp_a;
    logic  chk_f;
    logic  exp_f;
    string tag;
  } exp_item_t;
  exp_item_t sb[$];

  always #2 clk = ~clk;

  rx_ais_detector #(.WIN_BITS(WIN), .ZERO_LIMIT(LIMIT)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .in_frame_start(in_frame_start), .mode(mode),
    .rx_oh_mark(rx_oh_mark), .tx_oh_mark(tx_oh_mark), .dlb_active(dlb_active),
    .allones_det(allones_det), .framed_ais_det(framed_ais_det)
  );

  // Monitor: compares queued expectations away from the active edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      exp_item_t it;
      it = sb.pop_front();
      n_cmp++;
      if (in_ready !== 1'b1) begin
        n_bad++;
        $display("FAIL R9 (%s): in_ready=%b expected 1", it.tag, in_ready);
      end else if (it.chk_a && allones_det !== it.exp_a) begin
        n_bad++;
        $display("FAIL %s: allones_det=%b expected %b", it.tag, allones_det, it.exp_a);
      end else if (it.chk_f && framed_ais_det !== it.exp_f) begin
        n_bad++;
        $display("FAIL %s: framed_ais_det=%b expected %b", it.tag, framed_ais_det, it.exp_f);
      end
    end
  end

  task automatic expect_flags(input logic ca, input logic ea, input logic cf,
                              input logic ef, input string tag);
    exp_item_t it;
    it.chk_a = ca; it.exp_a = ea; it.chk_f = cf; it.exp_f = ef; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic put(input logic b, input logic rxo, input logic txo, input logic fs);
    @(negedge clk);
    in_valid = 1'b1; in_bit = b; rx_oh_mark = rxo; tx_oh_mark = txo; in_frame_start = fs;
    @(posedge clk);
  endtask

  task automatic idle(input int n, input logic b);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; in_bit = b; in_frame_start = 1'b1; rx_oh_mark = 1'b0; tx_oh_mark = 1'b0;
      @(posedge clk);
    end
    @(negedge clk);
    in_frame_start = 1'b0;
  endtask

  // One window of counted bits; the first nz carry a zero with the given marks
  task automatic window(input int nz, input logic zrx, input logic ztx);
    for (int i = 0; i < WIN; i++) begin
      if (i < nz) put(1'b0, zrx, ztx, 1'b0);
      else        put(1'b1, 1'b0, 1'b0, 1'b0);
    end
  endtask

  task automatic set_mode(input logic [1:0] m, input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_bit = 1'b1; in_frame_start = 1'b0; mode = m;
    @(posedge clk);
    expect_flags(1'b1, 1'b0, 1'b1, 1'b0, tag);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // M-frame: BLKS blocks of one overhead zero and PAY payload bits 1,0,1,0...
  task automatic frame(input int nerr, input logic ef, input string tag);
    int p;
    p = 0;
    for (int b = 0; b < BLKS; b++) begin
      put(1'b0, 1'b1, 1'b0, b == 0);
      if (b == 0) expect_flags(1'b0, 1'b0, 1'b1, ef, tag);
      for (int k = 0; k < PAY; k++) begin
        logic v;
        v = (k % 2 == 0);
        if (p < nerr) v = ~v;
        p++;
        put(v, 1'b0, 1'b0, 1'b0);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run hung, done=0 expected 1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    expect_flags(1'b1, 1'b0, 1'b1, 1'b0, "R1 reset state");

    set_mode(2'b01, "R8 enter E3");
    window(2, 1'b0, 1'b0);
    expect_flags(1'b1, 1'b1, 1'b0, 1'b0, "R2 two zeros sets");
    window(4, 1'b0, 1'b0);
    expect_flags(1'b1, 1'b0, 1'b0, 1'b0, "R3 limit+1 zeros clears");
    idle(40, 1'b1);
    expect_flags(1'b1, 1'b0, 1'b1, 1'b0, "R9 invalid ones ignored");
    window(3, 1'b0, 1'b0);
    expect_flags(1'b1, 1'b1, 1'b0, 1'b0, "R3 exactly limit zeros sets");

    // R4: receive marker honoured, transmit marker ignored
    for (int i = 0; i < 10; i++) put(1'b0, 1'b1, 1'b0, 1'b0);
    window(0, 1'b0, 1'b0);
    expect_flags(1'b1, 1'b1, 1'b0, 1'b0, "R4 rx-marked zeros excluded");
    window(4, 1'b0, 1'b1);
    expect_flags(1'b1, 1'b0, 1'b0, 1'b0, "R4 tx mark ignored without loopback");

    // R5: loopback swaps the marker
    @(negedge clk); dlb_active = 1'b1;
    for (int i = 0; i < 10; i++) put(1'b0, 1'b0, 1'b1, 1'b0);
    window(0, 1'b0, 1'b0);
    expect_flags(1'b1, 1'b1, 1'b0, 1'b0, "R5 tx-marked zeros excluded");
    window(4, 1'b1, 1'b0);
    expect_flags(1'b1, 1'b0, 1'b0, 1'b0, "R5 rx mark ignored under loopback");
    @(negedge clk); dlb_active = 1'b0;

    // R8: mode change mid-window realigns the window
    window(0, 1'b0, 1'b0);
    expect_flags(1'b1, 1'b1, 1'b0, 1'b0, "R2 clean window sets");
    for (int i = 0; i < 20; i++) put(1'b1, 1'b0, 1'b0, 1'b0);
    set_mode(2'b10, "R8 flags cleared on mode change");
    for (int i = 0; i < 12; i++) put(1'b1, 1'b0, 1'b0, 1'b0);
    expect_flags(1'b1, 1'b0, 1'b0, 1'b0, "R8 old window position dropped");
    for (int i = 0; i < 20; i++) put(1'b1, 1'b0, 1'b0, 1'b0);
    expect_flags(1'b1, 1'b1, 1'b0, 1'b0, "R7 all-ones in clear-channel");

    // R7: framed pattern not reported outside DS3
    frame(0, 1'b0, "R7 clear-channel framed low");
    frame(0, 1'b0, "R7 clear-channel framed low");
    set_mode(2'b01, "R8 enter E3 again");
    frame(0, 1'b0, "R7 E3 framed low");
    frame(0, 1'b0, "R7 E3 framed low");

    // R6: DS3 framed detection
    set_mode(2'b00, "R8 enter DS3");
    frame(0, 1'b0, "R6 first frame start only arms");
    frame(3, 1'b1, "R6 clean frame sets");
    frame(4, 1'b1, "R6 limit mismatches keeps set");
    frame(0, 1'b0, "R6 limit+1 mismatches clears");
    frame(0, 1'b1, "R6 clean frame sets again");
    window(0, 1'b0, 1'b0);
    expect_flags(1'b1, 1'b1, 1'b1, 1'b1, "R7 all-ones in DS3");
    set_mode(2'b01, "R8 framed cleared on leaving DS3");

    idle(3, 1'b0);
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule